// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory cycles of an 8-bit controller whose pins share the low address byte and the data byte on one port, with the high address byte on a second port. Timing is counted in oscillator clocks. Two clocks make one state, and six states make one 12-clock machine cycle. The block cycles through fixed-length slots. Each short slot lasts 6 clocks and is either an idle slot (`SL_IDLE`) or a code fetch (`SL_CODE`). Each long slot lasts 12 clocks and is either a data read (`SL_DRD`) or a data write (`SL_DWR`). Every slot opens with a two-clock active-low address-latch pulse (`ale_n`). The external latch is transparent while `ale_n` is low and captures the low address byte when `ale_n` rises. Because idle and code slots each produce a pulse, ALE runs at one sixth of the oscillator rate. A long data slot gives up its second pulse.

A requester pulses `go` for one clock while `busy` is low, with a kind code, a 16-bit address and, for writes, a data byte. The request waits in a single-entry holding register until the current slot ends. At that slot boundary (transition `at_end`) the next slot is chosen: the held kind if a request is pending, otherwise `SL_IDLE`. Every slot returns to the same decision at its own boundary, so the named transitions are IDLE→IDLE, IDLE→CODE, IDLE→DRD and IDLE→DWR, and the same four from CODE, DRD and DWR. Code fetches use the program-store strobe `psen_n`. Data accesses use `rd_n` or `wr_n`. Code and data are separate 64 KB spaces. When a slot finishes, `done` pulses for one clock and `rdata` holds the byte read.

All pin outputs are registered. They are decoded from the next state and phase, so they change only on clock edges and always match the current slot and phase.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst_n` is low, `ale_n`, `psen_n`, `rd_n` and `wr_n` are 1, and `ad_oe`, `a_hi_oe`, `busy` and `done` are 0.
- R2: Through idle and code slots, `ale_n` is low for exactly 2 clocks, and successive falling edges of `ale_n` are 6 clocks apart.
- R3: In a non-idle slot, `ad_out` carries `addr[7:0]` with `ad_oe` high from the clock in which `ale_n` falls until one clock after `ale_n` rises, with the value unchanged across the rise. `a_hi` equals `addr[15:8]` and `a_hi_oe` is high for the whole slot.
- R4: A code fetch (kind 2'b00) drives `psen_n` low for 3 clocks (slot phases 3 to 5) with `ad_oe` low. `rdata` takes `ad_in` as sampled on the edge at which `psen_n` rises.
- R5: A data read (kind 2'b01) occupies a 12-clock slot. `rd_n` is low for 6 clocks (phases 4 to 9) and `ad_oe` is low from phase 3 onward. `rdata` takes `ad_in` as sampled on the edge at which `rd_n` rises.
- R6: A data write (kind 2'b10) occupies a 12-clock slot. `ad_out` carries `wdata` with `ad_oe` high from phase 3 through phase 10, so the data is held one clock past the rise of `wr_n`. `wr_n` is low for 6 clocks (phases 4 to 9).
- R7: A data slot has only one ALE pulse, so the falling edge of `ale_n` after a data access comes 12 clocks after the one that opened it.
- R8: `done` is high for exactly one clock per completed access, in the clock after the slot's last phase (the clock in which the next slot's `ale_n` falls). `busy` is low in that clock.
- R9: `go` is taken only while `busy` is low. `busy` is high in the clock after it is taken. A `go` while `busy` is high starts no access. The accepted access's `ale_n` falls between 2 and 7 clocks after the clock in which `go` was high.
- R10: `go` with kind 2'b11 is not taken. `busy` stays low and no strobe follows.
- R11: At most one of `psen_n`, `rd_n`, `wr_n` is low at any time, and `ad_oe` is low whenever `psen_n` or `rd_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | One-clock request pulse |
| kind | input | 2 | 00 code fetch, 01 data read, 10 data write, 11 no request |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| busy | output | 1 | A request is held or an access slot is running |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last byte read from code or data memory |
| ale_n | output | 1 | Active-low address latch enable |
| psen_n | output | 1 | Active-low code read strobe |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |
| ad_out | output | 8 | Multiplexed low address / write data out |
| ad_oe | output | 1 | Output enable for the multiplexed port |
| ad_in | input | 8 | Multiplexed port input (read data) |
| a_hi | output | 8 | High address byte |
| a_hi_oe | output | 1 | Output enable for the high address port |

## Verification
Every result is timed from the falling edge of `ale_n` that opens a slot. `done` arrives 6 clocks after that edge for a code fetch and 12 clocks after it for a data access, in the same clock as the next slot's ALE fall. The ALE spacing seen at the `done` sample must therefore be 6 or 12. Read data appears on `rdata` by the `done` clock, and a write reaches the bench's memory model at the clock in which `wr_n` rises. The bench's memory models return a wrong byte (8'hEE) in every strobe clock except the last, so a sampling edge that is off by even one clock is caught. All outputs are sampled 1 ns after the falling clock edge. Strobe widths, ALE low time and the spacing between ALE falls are counted in clocks by a monitor, and the tasks compare those counts once `done` has been seen.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    // Oscillator clocks per state; a machine cycle is six states.
    localparam int CPS  = 2;
    localparam int PH_W = 4;
    typedef logic [PH_W-1:0] ph_t;

    localparam ph_t PH_SHORT_LAST = ph_t'(3 * CPS - 1);   // 6-clock slot
    localparam ph_t PH_LONG_LAST  = ph_t'(6 * CPS - 1);   // 12-clock slot
    localparam ph_t PH_ALE_LAST   = ph_t'(CPS - 1);       // ALE low in state 0
    localparam ph_t PH_ADDR_HOLD  = ph_t'(CPS);           // address held past ALE
    localparam ph_t PH_CODE_STB   = ph_t'(CPS + 1);       // program strobe start
    localparam ph_t PH_DSTB_ON    = ph_t'(2 * CPS);       // data strobe start
    localparam ph_t PH_DSTB_LAST  = ph_t'(5 * CPS - 1);   // data strobe end
    localparam ph_t PH_WDATA_LAST = ph_t'(5 * CPS);       // write data hold

    typedef enum logic [1:0] {
        REQ_CODE = 2'd0,
        REQ_DRD  = 2'd1,
        REQ_DWR  = 2'd2,
        REQ_NONE = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        SL_IDLE,
        SL_CODE,
        SL_DRD,
        SL_DWR
    } slot_e;
endpackage

// File: rtl/xbus_sched.sv
module xbus_sched
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output slot_e             slot_q,
    output ph_t               ph_q,
    output slot_e             slot_d,
    output ph_t               ph_d,
    output logic [ADDR_W-1:0] addr_d,
    output logic [DATA_W-1:0] wdata_d
);
    slot_e             slot_r, slot_n;
    ph_t               ph_r, ph_n;
    logic              pend_r;
    req_e              pend_kind;
    logic [ADDR_W-1:0] pend_addr, cur_addr, cur_addr_n;
    logic [DATA_W-1:0] pend_wdata, cur_wdata, cur_wdata_n;
    logic              at_end, busy_c, accept;

    // Next-state: advance the phase, choose the next slot at the boundary.
    always_comb begin
        if (slot_r == SL_DRD || slot_r == SL_DWR) begin
            at_end = (ph_r == PH_LONG_LAST);
        end else begin
            at_end = (ph_r == PH_SHORT_LAST);
        end
        busy_c      = pend_r || (slot_r != SL_IDLE);
        accept      = go && !busy_c && (kind != REQ_NONE);
        slot_n      = slot_r;
        ph_n        = ph_r + ph_t'(1);
        cur_addr_n  = cur_addr;
        cur_wdata_n = cur_wdata;
        if (at_end) begin
            ph_n   = '0;
            slot_n = SL_IDLE;
            if (pend_r) begin
                unique case (pend_kind)
                    REQ_CODE: slot_n = SL_CODE;
                    REQ_DRD:  slot_n = SL_DRD;
                    REQ_DWR:  slot_n = SL_DWR;
                    REQ_NONE: slot_n = SL_IDLE;
                endcase
                cur_addr_n  = pend_addr;
                cur_wdata_n = pend_wdata;
            end
        end
    end

    // State register and single-entry request hold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_r     <= SL_IDLE;
            ph_r       <= PH_SHORT_LAST;
            pend_r     <= 1'b0;
            pend_kind  <= REQ_NONE;
            pend_addr  <= '0;
            pend_wdata <= '0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
        end else begin
            slot_r    <= slot_n;
            ph_r      <= ph_n;
            cur_addr  <= cur_addr_n;
            cur_wdata <= cur_wdata_n;
            if (at_end && pend_r) begin
                pend_r <= 1'b0;
            end else if (accept) begin
                pend_r     <= 1'b1;
                pend_kind  <= req_e'(kind);
                pend_addr  <= addr;
                pend_wdata <= wdata;
            end
        end
    end

    assign busy    = busy_c;
    assign slot_q  = slot_r;
    assign ph_q    = ph_r;
    assign slot_d  = slot_n;
    assign ph_d    = ph_n;
    assign addr_d  = cur_addr_n;
    assign wdata_d = cur_wdata_n;
endmodule

// File: rtl/xbus_drive.sv
module xbus_drive
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  slot_e                    slot_d,
    input  ph_t                      ph_d,
    input  logic [ADDR_W-1:0]        addr_d,
    input  logic [DATA_W-1:0]        wdata_d,
    output logic                     ale_n,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe
);
    logic              ale_c, ps_c, rd_c, wr_c, oe_c, hioe_c;
    logic [DATA_W-1:0] ad_c;
    logic              addr_ph;

    // Pin decode for the coming slot and phase.
    always_comb begin
        ale_c   = (ph_d > PH_ALE_LAST);
        ps_c    = 1'b1;
        rd_c    = 1'b1;
        wr_c    = 1'b1;
        oe_c    = 1'b0;
        ad_c    = '0;
        hioe_c  = (slot_d != SL_IDLE);
        addr_ph = (ph_d <= PH_ADDR_HOLD);
        unique case (slot_d)
            SL_IDLE: begin
            end
            SL_CODE: begin
                if (addr_ph) begin
                    oe_c = 1'b1;
                    ad_c = addr_d[DATA_W-1:0];
                end
                if (ph_d >= PH_CODE_STB) ps_c = 1'b0;
            end
            SL_DRD: begin
                if (addr_ph) begin
                    oe_c = 1'b1;
                    ad_c = addr_d[DATA_W-1:0];
                end
                if (ph_d >= PH_DSTB_ON && ph_d <= PH_DSTB_LAST) rd_c = 1'b0;
            end
            SL_DWR: begin
                if (addr_ph) begin
                    oe_c = 1'b1;
                    ad_c = addr_d[DATA_W-1:0];
                end else if (ph_d <= PH_WDATA_LAST) begin
                    oe_c = 1'b1;
                    ad_c = wdata_d;
                end
                if (ph_d >= PH_DSTB_ON && ph_d <= PH_DSTB_LAST) wr_c = 1'b0;
            end
        endcase
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_n   <= 1'b1;
            psen_n  <= 1'b1;
            rd_n    <= 1'b1;
            wr_n    <= 1'b1;
            ad_oe   <= 1'b0;
            ad_out  <= '0;
            a_hi    <= '0;
            a_hi_oe <= 1'b0;
        end else begin
            ale_n   <= ale_c;
            psen_n  <= ps_c;
            rd_n    <= rd_c;
            wr_n    <= wr_c;
            ad_oe   <= oe_c;
            ad_out  <= ad_c;
            a_hi_oe <= hioe_c;
            if (hioe_c) a_hi <= addr_d[ADDR_W-1:DATA_W];
        end
    end

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
    // R11
    bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n) |-> !ad_oe);
    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ale_n) && $past(ad_oe)) |-> (ad_oe && $stable(ad_out)));
    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (ad_oe && $stable(ad_out)));
endmodule

// File: rtl/xbus_capture.sv
module xbus_capture
    import xbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  slot_e             slot_q,
    input  ph_t               ph_q,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rdata,
    output logic              done
);
    logic take, fin;

    always_comb begin
        take = 1'b0;
        fin  = 1'b0;
        unique case (slot_q)
            SL_IDLE: begin
            end
            SL_CODE: begin
                take = (ph_q == PH_SHORT_LAST);
                fin  = take;
            end
            SL_DRD: begin
                take = (ph_q == PH_DSTB_LAST);
                fin  = (ph_q == PH_LONG_LAST);
            end
            SL_DWR: begin
                fin  = (ph_q == PH_LONG_LAST);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            done  <= 1'b0;
        end else begin
            done <= fin;
            if (take) rdata <= ad_in;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go,
    input  logic [1:0]               kind,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ale_n,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe
);
    slot_e             slot_q, slot_d;
    ph_t               ph_q, ph_d;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;

    xbus_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .addr(addr),
        .wdata(wdata), .busy(busy), .slot_q(slot_q), .ph_q(ph_q),
        .slot_d(slot_d), .ph_d(ph_d), .addr_d(addr_d), .wdata_d(wdata_d)
    );

    xbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .slot_d(slot_d), .ph_d(ph_d),
        .addr_d(addr_d), .wdata_d(wdata_d), .ale_n(ale_n), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe)
    );

    xbus_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .slot_q(slot_q), .ph_q(ph_q),
        .ad_in(ad_in), .rdata(rdata), .done(done)
    );

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && kind != 2'b11) |=> busy);
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n, go;
    logic [1:0] kind;
    logic [15:0] addr;
    logic [7:0] wdata, rdata, ad_out, ad_in, a_hi;
    logic       busy, done, ale_n, psen_n, rd_n, wr_n, ad_oe, a_hi_oe;

    always #2 clk = ~clk;

    xbus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .go(go), .kind(kind), .addr(addr),
        .wdata(wdata), .busy(busy), .done(done), .rdata(rdata),
        .ale_n(ale_n), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .a_hi(a_hi),
        .a_hi_oe(a_hi_oe)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- bus monitor and memory models ----------------
    logic [7:0] dmem [0:255];
    logic [7:0] latch_lo, prev_ad, hi_seen;
    logic       prev_ale, prev_oe, prev_wr, prev_done, hioe_seen;
    int ncyc, last_fall, ale_gap, ale_cnt, ale_low_w, setup_err;
    int ps_cnt, rd_cnt, wr_cnt, ps_w, rd_w, wr_w, ps_ev, rd_ev, wr_ev;
    int overlap_err, done_cnt, done_err, wr_hold_err;

    function automatic logic [7:0] cval(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Memories return the correct byte only in the last clock of a strobe.
    assign ad_in = (!psen_n && ps_cnt >= 3) ? cval({a_hi, latch_lo}) :
                   (!rd_n && rd_cnt >= 6)   ? dmem[latch_lo] : 8'hEE;

    always @(negedge clk) begin
        if (!rst_n) begin
            ncyc = 0; last_fall = 0; ale_gap = 0; ale_cnt = 0; ale_low_w = 0;
            ps_cnt = 0; rd_cnt = 0; wr_cnt = 0;
            prev_ale = 1'b1; prev_oe = 1'b0; prev_wr = 1'b1; prev_done = 1'b0;
            prev_ad = 8'h00; latch_lo = 8'h00;
        end else begin
            ncyc = ncyc + 1;
            if (!ale_n && prev_ale) begin
                ale_gap = ncyc - last_fall;
                last_fall = ncyc;
            end
            if (!ale_n) ale_cnt = ale_cnt + 1;
            if (ale_n && !prev_ale) begin
                ale_low_w = ale_cnt;
                ale_cnt = 0;
                latch_lo = prev_ad;
                if (prev_oe && !(ad_oe && ad_out == prev_ad)) setup_err = setup_err + 1;
            end
            if (!psen_n) ps_cnt = ps_cnt + 1;
            else if (ps_cnt != 0) begin ps_w = ps_cnt; ps_cnt = 0; ps_ev = ps_ev + 1; end
            if (!rd_n) rd_cnt = rd_cnt + 1;
            else if (rd_cnt != 0) begin rd_w = rd_cnt; rd_cnt = 0; rd_ev = rd_ev + 1; end
            if (!wr_n) wr_cnt = wr_cnt + 1;
            else if (wr_cnt != 0) begin wr_w = wr_cnt; wr_cnt = 0; wr_ev = wr_ev + 1; end
            if (!psen_n || !rd_n || !wr_n) begin
                hi_seen = a_hi;
                hioe_seen = a_hi_oe;
            end
            if ((!psen_n || !rd_n) && ad_oe) overlap_err = overlap_err + 1;
            if ((!psen_n && !rd_n) || (!psen_n && !wr_n) || (!rd_n && !wr_n))
                overlap_err = overlap_err + 1;
            if (wr_n && !prev_wr) begin
                if (ad_oe) dmem[latch_lo] = ad_out;
                else wr_hold_err = wr_hold_err + 1;
            end
            if (done) begin
                done_cnt = done_cnt + 1;
                if (prev_done || busy) done_err = done_err + 1;
            end
            prev_ale = ale_n; prev_oe = ad_oe; prev_ad = ad_out;
            prev_wr = wr_n; prev_done = done;
        end
    end

    // ---------------- helpers ----------------
    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    int t_go;

    task automatic issue(input logic [1:0] k, input logic [15:0] a, input logic [7:0] d);
        while (busy) tick;
        kind = k; addr = a; wdata = d; go = 1'b1;
        t_go = ncyc;
        tick;
        go = 1'b0;
        // R9: busy rises the clock after the request is taken
        chk(busy == 1'b1, "R9 busy after go", int'(busy), 1);
    endtask

    task automatic wait_done;
        do tick; while (!done);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset;
        // R1
        chk({ale_n, psen_n, rd_n, wr_n} == 4'hF, "R1 strobes idle", int'({ale_n, psen_n, rd_n, wr_n}), 15);
        chk({ad_oe, a_hi_oe, busy, done} == 4'h0, "R1 enables/flags", int'({ad_oe, a_hi_oe, busy, done}), 0);
    endtask

    task automatic t_idle_ale;
        repeat (20) tick;
        // R2
        chk(ale_gap == 6, "R2 idle ALE spacing", ale_gap, 6);
        chk(ale_low_w == 2, "R2 ALE low width", ale_low_w, 2);
    endtask

    task automatic t_code(input logic [15:0] a);
        int rd0, wr0, dn0;
        rd0 = rd_ev; wr0 = wr_ev; dn0 = done_cnt;
        issue(2'b00, a, 8'h00);
        wait_done;
        // R4
        chk(rdata == cval(a), "R4 code rdata", rdata, cval(a));
        chk(ps_w == 3, "R4 psen width", ps_w, 3);
        chk(rd_ev == rd0 && wr_ev == wr0, "R4 no data strobe", rd_ev + wr_ev, rd0 + wr0);
        // R3
        chk(latch_lo == a[7:0], "R3 latched low addr", latch_lo, a[7:0]);
        chk(hi_seen == a[15:8] && hioe_seen, "R3 high addr", hi_seen, a[15:8]);
        chk(setup_err == 0, "R3 addr hold", setup_err, 0);
        // R2
        chk(ale_gap == 6, "R2 code ALE spacing", ale_gap, 6);
        // R8
        chk(done_cnt == dn0 + 1 && done_err == 0, "R8 done pulse", done_cnt - dn0, 1);
        // R9
        chk((last_fall - ale_gap - t_go) >= 2 && (last_fall - ale_gap - t_go) <= 7,
            "R9 start latency", last_fall - ale_gap - t_go, 7);
    endtask

    task automatic t_write(input logic [15:0] a, input logic [7:0] d);
        issue(2'b10, a, d);
        wait_done;
        // R6
        chk(dmem[a[7:0]] == d, "R6 written byte", dmem[a[7:0]], d);
        chk(wr_w == 6, "R6 wr width", wr_w, 6);
        chk(wr_hold_err == 0, "R6 data held past wr", wr_hold_err, 0);
        chk(hi_seen == a[15:8], "R3 write high addr", hi_seen, a[15:8]);
        // R7
        chk(ale_gap == 12, "R7 write ALE spacing", ale_gap, 12);
    endtask

    task automatic t_read(input logic [15:0] a);
        logic [7:0] exp;
        exp = dmem[a[7:0]];
        issue(2'b01, a, 8'h00);
        wait_done;
        // R5
        chk(rdata == exp, "R5 read rdata", rdata, exp);
        chk(rd_w == 6, "R5 rd width", rd_w, 6);
        chk(latch_lo == a[7:0], "R3 read low addr", latch_lo, a[7:0]);
        // R7
        chk(ale_gap == 12, "R7 read ALE spacing", ale_gap, 12);
    endtask

    task automatic t_busy_ignore;
        int ps0, dn0;
        logic [7:0] exp;
        exp = dmem[8'h10];
        ps0 = ps_ev; dn0 = done_cnt;
        issue(2'b01, 16'h1210, 8'h00);
        repeat (3) tick;
        kind = 2'b00; addr = 16'h7777; go = 1'b1;
        tick;
        go = 1'b0;
        wait_done;
        repeat (20) tick;
        // R9
        chk(ps_ev == ps0, "R9 go while busy ignored", ps_ev - ps0, 0);
        chk(done_cnt == dn0 + 1, "R9 single completion", done_cnt - dn0, 1);
        chk(rdata == exp, "R9 read unaffected", rdata, exp);
    endtask

    task automatic t_kind_none;
        int ev0;
        ev0 = ps_ev + rd_ev + wr_ev;
        while (busy) tick;
        kind = 2'b11; addr = 16'h4242; go = 1'b1;
        tick;
        go = 1'b0;
        // R10
        chk(busy == 1'b0, "R10 kind 3 not taken", busy, 0);
        repeat (16) tick;
        chk(ps_ev + rd_ev + wr_ev == ev0, "R10 no strobe", ps_ev + rd_ev + wr_ev, ev0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        setup_err = 0; overlap_err = 0; done_err = 0; wr_hold_err = 0;
        done_cnt = 0; ps_ev = 0; rd_ev = 0; wr_ev = 0; ps_w = 0; rd_w = 0; wr_w = 0;
        hi_seen = 8'h00; hioe_seen = 1'b0;
        rst_n = 1'b0; go = 1'b0; kind = 2'b00; addr = 16'h0000; wdata = 8'h00;
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i) ^ 8'hA5;
        repeat (3) tick;
        t_reset;
        rst_n = 1'b1;
        t_idle_ale;
        t_code(16'h0000);
        t_code(16'hA35C);
        t_code(16'hFFFF);
        t_write(16'h8033, 8'h5A);
        t_read(16'h8033);
        t_read(16'h01C7);
        t_write(16'hFF00, 8'hC3);
        t_code(16'h1234);
        t_read(16'h2200);
        t_busy_ignore;
        t_kind_none;
        // R11
        chk(overlap_err == 0, "R11 strobe exclusivity", overlap_err, 0);
        // R8
        chk(done_err == 0, "R8 done single and not busy", done_err, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule